// File: doc/BRIEF.md
# DSP-to-Host Event Mailbox

This block moves one event record from a signal-processor clock domain to a host microcontroller clock domain. A record is a command byte plus a 16-bit data word. On the DSP side, software first writes the data word into a staging register. It then writes the command byte. The command write is the only trigger: it freezes the byte and the staged word into hold registers and flips a request toggle. The record is sent at most once per 125 µs frame, so the hold registers stay stable for far longer than the host needs to sample them.

On the host side, the toggle passes through a two-flop synchronizer. An edge detector turns it into a single-cycle commit pulse. That pulse loads three byte registers, which the host reads through a byte-select port. The same pulse raises an event interrupt. Only the DSP-originated pulse can set the interrupt, so it can wake a sleeping host. The interrupt is kept by a small state machine with three states:
- `H_IDLE`: no event is waiting.
- `H_PEND`: one event is unread.
- `H_OVER`: an event arrived while the previous one was still flagged.

The transitions are:
- `EV_NEW`: `H_IDLE`→`H_PEND` on a commit.
- `EV_LOST`: `H_PEND`→`H_OVER` on a commit without a clear.
- `EV_ACK`: `H_PEND` or `H_OVER`→`H_IDLE` on a clear without a commit.
- `EV_ACK_NEW`: `H_PEND` or `H_OVER`→`H_PEND` when a clear and a commit fall in the same cycle.

`H_OVER` stays in `H_OVER` on further commits.

Top module: `dsp_evt_mailbox`

## Requirements
- R1: After reset, `host_irq` and `host_ovr` are 0 and every selectable byte reads 0.
- R2: A DSP control write (`dsp_wr_addr`=1) delivers a record that the host reads as follows: select 0 gives the command byte, select 1 gives data bits 7:0, select 2 gives data bits 15:8, and select 3 reads 0.
- R3: The host byte registers and `host_irq` change on the third `host_clk` rising edge after the DSP edge that performed the control write, and not earlier.
- R4: A data write (`dsp_wr_addr`=0) with no later control write changes neither `host_irq` nor any host byte.
- R5: `host_irq` stays 1 until the host pulses `host_irq_clr`. A clear without a simultaneous commit drops it at the next host edge.
- R6: A commit arriving while `host_irq` is 1 and no clear is present sets `host_ovr`. The byte registers then hold the newest record.
- R7: A clear and a commit landing in the same host cycle leave `host_irq`=1 and `host_ovr`=0, with the new record readable.
- R8: A clear while no event is flagged has no effect: `host_irq` and `host_ovr` remain 0.
- R9: A commit carries the most recent data write; earlier data writes are replaced.
- R10: The command byte is taken from `dsp_wr_data[7:0]` of the control write; bits 15:8 of that write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dsp_clk | input | 1 | DSP-domain clock |
| dsp_rst_n | input | 1 | DSP-domain asynchronous reset, active low |
| dsp_wr_en | input | 1 | DSP register write strobe |
| dsp_wr_addr | input | 1 | 0 = data staging register, 1 = control (commit) register |
| dsp_wr_data | input | 16 | DSP write data |
| host_clk | input | 1 | Host-domain clock |
| host_rst_n | input | 1 | Host-domain asynchronous reset, active low |
| host_irq_clr | input | 1 | Host write that clears the event flag and overrun bit |
| host_rd_sel | input | 2 | Byte select: 0 command, 1 data low, 2 data high |
| host_rd_data | output | 8 | Selected byte |
| host_irq | output | 1 | Event interrupt request |
| host_ovr | output | 1 | Overrun: an event arrived before the previous one was cleared |

## Verification
The host's clear write and the arrival of a synchronized commit can fall in the same host cycle. Both act on the flag state machine, with opposite intent. The bench provokes this case by counting host edges after the DSP commit edge: the synchronizer delay is fixed at three edges, so the clear is held high across exactly the edge where the pulse lands. The case is run once from `H_PEND` and once from `H_OVER`. Each time the bench judges that the flag stays set, the overrun bit is cleared, and the new record is readable. A neighbouring run places a commit against a set flag with no clear and expects the overrun bit to rise.

// File: rtl/dsp_evt_mailbox_pkg.sv
package dsp_evt_mailbox_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        H_IDLE = 2'd0,
        H_PEND = 2'd1,
        H_OVER = 2'd2
    } host_state_e;

endpackage

// File: rtl/mbx_dsp_regs.sv
module mbx_dsp_regs
    import dsp_evt_mailbox_pkg::*;
#(
    parameter int DATA_BYTES = 2,
    localparam int DATA_W = DATA_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ctrl_hold,
    output logic [DATA_W-1:0] data_hold,
    output logic              req_tgl
);

    logic [DATA_W-1:0] data_stage;
    logic              wr_data_reg;
    logic              wr_ctrl_reg;

    always_comb begin
        wr_data_reg = wr_en && !wr_addr;
        wr_ctrl_reg = wr_en &&  wr_addr;
    end

    // staging register: overwritten by every data write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_stage <= '0;
        end else if (wr_data_reg) begin
            data_stage <= wr_data;
        end
    end

    // commit: control write freezes the record and flips the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_hold <= '0;
            data_hold <= '0;
            req_tgl   <= 1'b0;
        end else if (wr_ctrl_reg) begin
            ctrl_hold <= wr_data[BYTE_W-1:0];
            data_hold <= data_stage;
            req_tgl   <= ~req_tgl;
        end
    end

endmodule

// File: rtl/mbx_tgl_sync.sv
module mbx_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);

    logic [STAGES-1:0] sh;
    logic              last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[0] <= 1'b0;
                    else        sh[0] <= tgl_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[i] <= 1'b0;
                    else        sh[i] <= sh[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= sh[STAGES-1];
    end

    always_comb pulse = sh[STAGES-1] ^ last;

endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
    import dsp_evt_mailbox_pkg::*;
#(
    parameter int DATA_BYTES = 2,
    localparam int DATA_W = DATA_BYTES * BYTE_W,
    localparam int N_SEL  = DATA_BYTES + 1,
    localparam int SEL_W  = $clog2(N_SEL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              irq_clr,
    input  logic [BYTE_W-1:0] ctrl_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] data_q,
    output logic              irq,
    output logic              ovr
);

    host_state_e state_q, state_d;
    logic [BYTE_W-1:0] bytes [N_SEL];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= H_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE: if (commit) state_d = H_PEND;                       // EV_NEW
            H_PEND: begin
                if (commit && irq_clr)  state_d = H_PEND;               // EV_ACK_NEW
                else if (commit)        state_d = H_OVER;               // EV_LOST
                else if (irq_clr)       state_d = H_IDLE;               // EV_ACK
            end
            H_OVER: begin
                if (commit && irq_clr)  state_d = H_PEND;               // EV_ACK_NEW
                else if (irq_clr)       state_d = H_IDLE;               // EV_ACK
            end
            default: state_d = H_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq = 1'b0;
        ovr = 1'b0;
        unique case (state_q)
            H_IDLE: begin irq = 1'b0; ovr = 1'b0; end
            H_PEND: begin irq = 1'b1; ovr = 1'b0; end
            H_OVER: begin irq = 1'b1; ovr = 1'b1; end
            default: begin irq = 1'b0; ovr = 1'b0; end
        endcase
    end

    // record registers, loaded only by the synchronized commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else if (commit) begin
            ctrl_q <= ctrl_in;
            data_q <= data_in;
        end
    end

    // byte view: index 0 command, index k data byte k-1
    always_comb bytes[0] = ctrl_q;
    generate
        for (genvar k = 1; k < N_SEL; k++) begin : g_byte
            always_comb bytes[k] = data_q[(k-1)*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int j = 0; j < N_SEL; j++) begin
            if (rd_sel == SEL_W'(j)) rd_data = bytes[j];
        end
    end

endmodule

// File: rtl/dsp_evt_mailbox.sv
module dsp_evt_mailbox
    import dsp_evt_mailbox_pkg::*;
#(
    parameter int DATA_BYTES  = 2,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W = DATA_BYTES * BYTE_W,
    localparam int SEL_W  = $clog2(DATA_BYTES + 2)
) (
    input  logic              dsp_clk,
    input  logic              dsp_rst_n,
    input  logic              dsp_wr_en,
    input  logic              dsp_wr_addr,
    input  logic [DATA_W-1:0] dsp_wr_data,
    input  logic              host_clk,
    input  logic              host_rst_n,
    input  logic              host_irq_clr,
    input  logic [SEL_W-1:0]  host_rd_sel,
    output logic [BYTE_W-1:0] host_rd_data,
    output logic              host_irq,
    output logic              host_ovr
);

    logic [BYTE_W-1:0] ctrl_hold;
    logic [DATA_W-1:0] data_hold;
    logic              req_tgl;
    logic              host_commit;
    logic [BYTE_W-1:0] host_ctrl_q;
    logic [DATA_W-1:0] host_data_q;

    mbx_dsp_regs #(.DATA_BYTES(DATA_BYTES)) u_dsp (
        .clk      (dsp_clk),
        .rst_n    (dsp_rst_n),
        .wr_en    (dsp_wr_en),
        .wr_addr  (dsp_wr_addr),
        .wr_data  (dsp_wr_data),
        .ctrl_hold(ctrl_hold),
        .data_hold(data_hold),
        .req_tgl  (req_tgl)
    );

    mbx_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (host_clk),
        .rst_n (host_rst_n),
        .tgl_in(req_tgl),
        .pulse (host_commit)
    );

    mbx_host_regs #(.DATA_BYTES(DATA_BYTES)) u_host (
        .clk    (host_clk),
        .rst_n  (host_rst_n),
        .commit (host_commit),
        .irq_clr(host_irq_clr),
        .ctrl_in(ctrl_hold),
        .data_in(data_hold),
        .rd_sel (host_rd_sel),
        .rd_data(host_rd_data),
        .ctrl_q (host_ctrl_q),
        .data_q (host_data_q),
        .irq    (host_irq),
        .ovr    (host_ovr)
    );

endmodule

// File: rtl/dsp_evt_mailbox_chk.sv
module dsp_evt_mailbox_chk #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              irq_clr,
    input logic              irq,
    input logic              ovr,
    input logic [BYTE_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] data_q
);

    // R3: the flag can only rise in the cycle after a synchronized commit
    p_irq_rise_needs_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(commit));

    // R2: every commit leaves an event flagged
    p_commit_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> irq);

    // R4: record registers move only on a commit
    p_record_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ctrl_q) && $stable(data_q)));

    // R5: sticky until cleared
    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R5: a plain clear drops the flag
    p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !commit) |=> (!irq && !ovr));

    // R6: overrun only alongside a flagged event
    p_ovr_with_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> irq);

    // R6: commit against a set flag, no clear, marks overrun
    p_overrun_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && commit && !irq_clr) |=> ovr);

    // R7: clear and commit together keep the flag, drop overrun
    p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && irq_clr) |=> (irq && !ovr));

endmodule

bind dsp_evt_mailbox dsp_evt_mailbox_chk u_chk (
    .clk    (host_clk),
    .rst_n  (host_rst_n),
    .commit (host_commit),
    .irq_clr(host_irq_clr),
    .irq    (host_irq),
    .ovr    (host_ovr),
    .ctrl_q (host_ctrl_q),
    .data_q (host_data_q)
);

// File: tb/test_dsp_evt_mailbox.sv
module test_dsp_evt_mailbox;

    logic        dsp_clk = 1'b0;
    logic        host_clk = 1'b0;
    logic        dsp_rst_n = 1'b0;
    logic        host_rst_n = 1'b0;
    logic        dsp_wr_en = 1'b0;
    logic        dsp_wr_addr = 1'b0;
    logic [15:0] dsp_wr_data = '0;
    logic        host_irq_clr = 1'b0;
    logic [1:0]  host_rd_sel = '0;
    logic [7:0]  host_rd_data;
    logic        host_irq;
    logic        host_ovr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 host_clk = ~host_clk;   // 50 MHz
    always #7  dsp_clk  = ~dsp_clk;    // edges never coincide with host edges

    dsp_evt_mailbox i_dsp_evt_mailbox (
        .dsp_clk     (dsp_clk),
        .dsp_rst_n   (dsp_rst_n),
        .dsp_wr_en   (dsp_wr_en),
        .dsp_wr_addr (dsp_wr_addr),
        .dsp_wr_data (dsp_wr_data),
        .host_clk    (host_clk),
        .host_rst_n  (host_rst_n),
        .host_irq_clr(host_irq_clr),
        .host_rd_sel (host_rd_sel),
        .host_rd_data(host_rd_data),
        .host_irq    (host_irq),
        .host_ovr    (host_ovr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // returns 1 ns after the DSP edge that performs the write
    task automatic dsp_write(input logic addr, input logic [15:0] d);
        @(posedge dsp_clk); #1;
        dsp_wr_en = 1'b1; dsp_wr_addr = addr; dsp_wr_data = d;
        @(posedge dsp_clk); #1;
        dsp_wr_en = 1'b0;
    endtask

    task automatic host_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge host_clk);
        #2;
    endtask

    task automatic host_clear();
        @(posedge host_clk); #1; host_irq_clr = 1'b1;
        @(posedge host_clk); #1; host_irq_clr = 1'b0;
        #1;
    endtask

    task automatic check_record(input string req, input logic [7:0] c, input logic [15:0] d);
        host_rd_sel = 2'd0; #1; check(req, host_rd_data, c);
        host_rd_sel = 2'd1; #1; check(req, host_rd_data, d[7:0]);
        host_rd_sel = 2'd2; #1; check(req, host_rd_data, d[15:8]);
        host_rd_sel = 2'd3; #1; check(req, host_rd_data, 0);
    endtask

    task automatic t_reset();
        check("R1 irq", host_irq, 0);
        check("R1 ovr", host_ovr, 0);
        check_record("R1 bytes", 8'h00, 16'h0000);
    endtask

    task automatic t_clear_idle();
        host_clear();
        host_edges(1);
        check("R8 irq", host_irq, 0);
        check("R8 ovr", host_ovr, 0);
    endtask

    task automatic t_data_only();
        dsp_write(1'b0, 16'hDEAD);
        host_edges(8);
        check("R4 irq", host_irq, 0);
        check_record("R4 bytes", 8'h00, 16'h0000);
    endtask

    task automatic t_latency_and_commit();
        dsp_write(1'b0, 16'hBEEF);
        dsp_write(1'b1, 16'h5A3C);
        host_edges(2);
        check("R3 irq early", host_irq, 0);
        check_record("R3 bytes early", 8'h00, 16'h0000);
        host_edges(1);
        check("R3 irq landed", host_irq, 1);
        check("R3 ovr", host_ovr, 0);
        check_record("R2 R9 record", 8'h3C, 16'hBEEF);
        check("R10 upper bits ignored", host_rd_data, 0);
    endtask

    task automatic t_sticky_and_clear();
        host_edges(10);
        check("R5 sticky", host_irq, 1);
        host_clear();
        check("R5 cleared", host_irq, 0);
        check_record("R5 record kept", 8'h3C, 16'hBEEF);
    endtask

    task automatic t_latest_data();
        dsp_write(1'b0, 16'h1111);
        dsp_write(1'b0, 16'h2233);
        dsp_write(1'b1, 16'hFF44);
        host_edges(5);
        check("R9 irq", host_irq, 1);
        check_record("R9 R10 latest", 8'h44, 16'h2233);
    endtask

    task automatic t_overrun();
        dsp_write(1'b0, 16'h7788);
        dsp_write(1'b1, 16'h0099);
        host_edges(5);
        check("R6 irq", host_irq, 1);
        check("R6 ovr", host_ovr, 1);
        check_record("R6 newest", 8'h99, 16'h7788);
    endtask

    // clear held across exactly the edge where the commit lands
    task automatic collide(input string req, input logic [7:0] c, input logic [15:0] d);
        dsp_write(1'b0, d);
        dsp_write(1'b1, {8'h00, c});
        @(posedge host_clk);
        @(posedge host_clk); #1; host_irq_clr = 1'b1;
        @(posedge host_clk); #1; host_irq_clr = 1'b0;
        #1;
        check({req, " irq"}, host_irq, 1);
        check({req, " ovr"}, host_ovr, 0);
        check_record({req, " record"}, c, d);
    endtask

    task automatic t_collide_from_over();
        collide("R7 from overrun", 8'hA1, 16'hC0DE);
    endtask

    task automatic t_collide_from_pend();
        collide("R7 from pending", 8'hB2, 16'hF00D);
        host_clear();
        check("R5 final clear", host_irq, 0);
    endtask

    initial begin
        host_edges(3);
        dsp_rst_n = 1'b1;
        host_rst_n = 1'b1;
        host_edges(1);
        t_reset();
        t_clear_idle();
        t_data_only();
        t_latency_and_commit();
        t_sticky_and_clear();
        t_latest_data();
        t_overrun();
        t_collide_from_over();
        t_collide_from_pend();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule